// File: doc/BRIEF.md
# Frame-Threshold Breakpoint Generator

This block decides when a receive path should interrupt its host. It counts received frames against a host-programmed threshold. When the programmed number of frames has arrived, it raises a breakpoint. It can also raise a breakpoint at the end of a service opportunity, or when the receive channel changes (the end of a burst). Three enable inputs select which of these sources are active. All of them merge into one registered pulse that lasts a single cycle.

The frame counter is a working register separate from the threshold input. It is loaded from the threshold only at reset, when the count runs out, and on every channel change. A host can therefore rewrite the threshold at any time without disturbing a count in progress. A threshold of zero stands for the full range of 2^CNT_W frames, which is 256 at the default width.

Top module: `frame_bkpt_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bkpt_o` is 0. Reset sets the working count to 2^CNT_W, so without a reload the first threshold breakpoint comes on the 256th enabled frame (default CNT_W = 8).
- R2: With a threshold N in 1..255 and `en_thresh_i` = 1, a breakpoint follows every Nth enabled frame, and the working count reloads to N each time it runs out.
- R3: A threshold value of 0 means 2^CNT_W frames. At the default width, 255 frames give no breakpoint and the 256th frame gives one.
- R4: A strobe on `chan_chg_stb_i` reloads the working count from `thresh_i`. A frame strobed in the same cycle counts as the first frame of the new load.
- R5: A change to `thresh_i` has no effect on a count in progress. It is picked up at the next reload, whether that reload comes from running out or from a channel change.
- R6: While `en_thresh_i` = 0, frame strobes are ignored. The working count does not move and no threshold breakpoint occurs. Counting resumes from the held value once the enable returns to 1.
- R7: A strobe on `svc_end_stb_i` with `en_svc_i` = 1 causes a breakpoint. With `en_svc_i` = 0 it causes none.
- R8: A strobe on `chan_chg_stb_i` with `en_burst_i` = 1 causes a breakpoint. With `en_burst_i` = 0 it causes none, but it still reloads the count.
- R9: When several breakpoint sources fire in the same cycle, they produce one breakpoint pulse, not one per source.
- R10: With REG_OUT = 1 (the default), `bkpt_o` goes high in the cycle after the causing strobe. It stays high for exactly one cycle unless a new cause arrives, and it is never high without a cause in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_stb_i | input | 1 | One-cycle strobe per received frame |
| svc_end_stb_i | input | 1 | One-cycle strobe at the end of a service opportunity |
| chan_chg_stb_i | input | 1 | One-cycle strobe when the receive channel state changes |
| thresh_i | input | CNT_W | Frame threshold; 0 means 2^CNT_W |
| en_thresh_i | input | 1 | Enables the frame-threshold source |
| en_svc_i | input | 1 | Enables the service-end source |
| en_burst_i | input | 1 | Enables the channel-change source |
| bkpt_o | output | 1 | Single-cycle breakpoint pulse |

## Verification
The frame counter is driven with back-to-back frame trains at thresholds of 1, 3, 5 and 0. These trains separate a correct modulus from an off-by-one, and show that zero is treated as the full range rather than as one. Some trains are interrupted by a channel change, some by a threshold rewrite, and some by dropping the enable. Those interruptions tell a reload apart from a mid-count update, and a frozen count apart from one that keeps running. The side sources are strobed with their enables set and cleared, and all sources are fired together. This shows that the enables gate each source and that coincident causes merge into a single pulse.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
   // Breakpoint source positions inside the merged cause vector
   typedef enum logic [1:0] {
      SRC_THRESH = 2'd0,
      SRC_SVC    = 2'd1,
      SRC_BURST  = 2'd2
   } bkpt_src_e;

   localparam int unsigned NUM_SRC = 3;
endpackage

// File: rtl/bkpt_work_ctr.sv
module bkpt_work_ctr #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             count_i,
   input  logic             reload_i,
   input  logic [CNT_W-1:0] thr_i,
   output logic             hit_o
);
   localparam int unsigned CW   = CNT_W + 1;
   localparam int unsigned FULL = 1 << CNT_W;

   logic [CW-1:0] work_q;
   logic [CW-1:0] load_v;
   logic [CW-1:0] base_v;
   logic [CW-1:0] next_v;
   logic          hit_v;

   // zero threshold stands for the full range
   always_comb begin
      load_v = (thr_i == '0) ? CW'(FULL) : {1'b0, thr_i};
   end

   // channel change reloads first; a same-cycle frame counts against the new load
   always_comb begin
      base_v = reload_i ? load_v : work_q;
      next_v = base_v;
      hit_v  = 1'b0;
      if (count_i) begin
         if (base_v == CW'(1)) begin
            hit_v  = 1'b1;
            next_v = load_v;
         end else begin
            next_v = base_v - CW'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_q <= CW'(FULL);
      end else begin
         work_q <= next_v;
      end
   end

   assign hit_o = hit_v;
endmodule

// File: rtl/bkpt_merge.sv
module bkpt_merge
   import bkpt_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [NUM_SRC-1:0] en_i,
   output logic               pulse_o
);
   logic cause;

   assign cause = |(src_i & en_i);

   generate
      if (REG_OUT) begin : g_reg
         logic pulse_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pulse_q <= 1'b0;
            end else begin
               pulse_q <= cause;
            end
         end
         assign pulse_o = pulse_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign pulse_o    = cause;
      end
   endgenerate
endmodule

// File: rtl/frame_bkpt_gen.sv
module frame_bkpt_gen
   import bkpt_pkg::*;
#(
   parameter int unsigned CNT_W   = 8,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_stb_i,
   input  logic             svc_end_stb_i,
   input  logic             chan_chg_stb_i,
   input  logic [CNT_W-1:0] thresh_i,
   input  logic             en_thresh_i,
   input  logic             en_svc_i,
   input  logic             en_burst_i,
   output logic             bkpt_o
);
   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("frame_bkpt_gen: CNT_W must lie in 2..16");
      end
   endgenerate

   logic               thr_hit;
   logic [NUM_SRC-1:0] src_vec;
   logic [NUM_SRC-1:0] en_vec;

   bkpt_work_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .count_i  (frame_stb_i & en_thresh_i),
      .reload_i (chan_chg_stb_i),
      .thr_i    (thresh_i),
      .hit_o    (thr_hit)
   );

   always_comb begin
      src_vec             = '0;
      en_vec              = '0;
      src_vec[SRC_THRESH] = thr_hit;
      src_vec[SRC_SVC]    = svc_end_stb_i;
      src_vec[SRC_BURST]  = chan_chg_stb_i;
      en_vec[SRC_THRESH]  = 1'b1;
      en_vec[SRC_SVC]     = en_svc_i;
      en_vec[SRC_BURST]   = en_burst_i;
   end

   bkpt_merge #(.REG_OUT(REG_OUT)) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_i   (src_vec),
      .en_i    (en_vec),
      .pulse_o (bkpt_o)
   );
endmodule

// File: rtl/bkpt_gen_chk.sv
module bkpt_gen_chk #(
   parameter int unsigned CNT_W   = 8,
   parameter bit          REG_OUT = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_stb_i,
   input logic             svc_end_stb_i,
   input logic             chan_chg_stb_i,
   input logic [CNT_W-1:0] thresh_i,
   input logic             en_thresh_i,
   input logic             en_svc_i,
   input logic             en_burst_i,
   input logic             bkpt_o
);
   generate
      if (REG_OUT) begin : g_reg_props
         // R10
         pulse_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bkpt_o |-> $past((frame_stb_i && en_thresh_i) ||
                             (svc_end_stb_i && en_svc_i) ||
                             (chan_chg_stb_i && en_burst_i)));
         // R7
         svc_bkpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (svc_end_stb_i && en_svc_i) |=> bkpt_o);
         // R8
         burst_bkpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_chg_stb_i && en_burst_i) |=> bkpt_o);
         // R6
         thresh_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_thresh_i && !(svc_end_stb_i && en_svc_i) &&
             !(chan_chg_stb_i && en_burst_i)) |=> !bkpt_o);
         // R4
         reload_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_chg_stb_i && frame_stb_i && en_thresh_i &&
             thresh_i == CNT_W'(1)) |=> bkpt_o);
      end
   endgenerate
endmodule

bind frame_bkpt_gen bkpt_gen_chk #(.CNT_W(CNT_W), .REG_OUT(REG_OUT)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .frame_stb_i    (frame_stb_i),
   .svc_end_stb_i  (svc_end_stb_i),
   .chan_chg_stb_i (chan_chg_stb_i),
   .thresh_i       (thresh_i),
   .en_thresh_i    (en_thresh_i),
   .en_svc_i       (en_svc_i),
   .en_burst_i     (en_burst_i),
   .bkpt_o         (bkpt_o)
);

// File: tb/tb_frame_bkpt_gen.sv
module tb_frame_bkpt_gen;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frm = 1'b0, svc = 1'b0, chg = 1'b0;
   logic [7:0] thr = 8'd0;
   logic       en_t = 1'b0, en_s = 1'b0, en_b = 1'b0;
   logic       bkpt;
   logic       got;
   int         n_chk = 0;
   int         n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frame_bkpt_gen dut (
      .clk(clk), .rst_n(rst_n), .frame_stb_i(frm), .svc_end_stb_i(svc),
      .chan_chg_stb_i(chg), .thresh_i(thr), .en_thresh_i(en_t),
      .en_svc_i(en_s), .en_burst_i(en_b), .bkpt_o(bkpt));

   task automatic chk(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic chk_int(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   // drive strobes for one cycle from a falling edge, sample the registered output after the edge
   task automatic tick(input logic f, input logic s, input logic c);
      frm = f; svc = s; chg = c;
      @(posedge clk);
      #(CLK_PERIOD/4);
      got = bkpt;
      @(negedge clk);
      frm = 1'b0; svc = 1'b0; chg = 1'b0;
   endtask

   // n frames, returns the number of pulses seen
   task automatic frames(input int n, output int pulses);
      pulses = 0;
      for (int i = 0; i < n; i++) begin
         tick(1'b1, 1'b0, 1'b0);
         if (got) pulses++;
      end
   endtask

   task automatic reload(input logic [7:0] t);
      thr = t;
      tick(1'b0, 1'b0, 1'b1);
   endtask

   task automatic t_reset;
      int p;
      chk("R1 low in reset", bkpt, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      thr = 8'd3; en_t = 1'b1;
      tick(1'b0, 1'b0, 1'b0);
      chk("R1 low after reset", got, 1'b0);
      frames(255, p);
      chk_int("R1 no pulse in first 255 frames", p, 0);
      tick(1'b1, 1'b0, 1'b0);
      chk("R1 pulse on frame 256", got, 1'b1);
   endtask

   task automatic t_modulus;
      int p;
      reload(8'd3);
      chk("R8 reload without burst enable is silent", got, 1'b0);
      frames(2, p); chk_int("R2 thr=3 first two frames", p, 0);
      tick(1'b1, 1'b0, 1'b0); chk("R2 thr=3 third frame", got, 1'b1);
      tick(1'b0, 1'b0, 1'b0); chk("R10 pulse lasts one cycle", got, 1'b0);
      frames(2, p); chk_int("R2 thr=3 after reload", p, 0);
      tick(1'b1, 1'b0, 1'b0); chk("R2 thr=3 sixth frame", got, 1'b1);
      reload(8'd1);
      frames(4, p); chk_int("R2 thr=1 every frame", p, 4);
   endtask

   task automatic t_zero;
      int p;
      reload(8'd0);
      frames(255, p); chk_int("R3 thr=0 255 frames silent", p, 0);
      tick(1'b1, 1'b0, 1'b0); chk("R3 thr=0 frame 256", got, 1'b1);
   endtask

   task automatic t_chan_reload;
      int p;
      reload(8'd4);
      frames(3, p); chk_int("R4 three frames of four", p, 0);
      tick(1'b1, 1'b0, 1'b1); chk("R4 reload with frame silent", got, 1'b0);
      frames(2, p); chk_int("R4 two more after reload", p, 0);
      tick(1'b1, 1'b0, 1'b0); chk("R4 fourth frame of new load", got, 1'b1);
   endtask

   task automatic t_thr_write;
      int p;
      reload(8'd5);
      frames(2, p);
      thr = 8'd2;
      frames(2, p); chk_int("R5 old count still running", p, 0);
      tick(1'b1, 1'b0, 1'b0); chk("R5 pulse at old threshold", got, 1'b1);
      tick(1'b1, 1'b0, 1'b0); chk("R5 new threshold first frame", got, 1'b0);
      tick(1'b1, 1'b0, 1'b0); chk("R5 new threshold second frame", got, 1'b1);
   endtask

   task automatic t_enable;
      int p;
      reload(8'd3);
      frames(2, p);
      en_t = 1'b0;
      frames(5, p); chk_int("R6 disabled frames silent", p, 0);
      en_t = 1'b1;
      tick(1'b1, 1'b0, 1'b0); chk("R6 count held while disabled", got, 1'b1);
   endtask

   task automatic t_side;
      en_s = 1'b1;
      tick(1'b0, 1'b1, 1'b0); chk("R7 service end enabled", got, 1'b1);
      tick(1'b0, 1'b0, 1'b0); chk("R10 service pulse one cycle", got, 1'b0);
      en_s = 1'b0;
      tick(1'b0, 1'b1, 1'b0); chk("R7 service end disabled", got, 1'b0);
      en_b = 1'b1;
      tick(1'b0, 1'b0, 1'b1); chk("R8 channel change enabled", got, 1'b1);
      tick(1'b0, 1'b0, 1'b0); chk("R10 burst pulse one cycle", got, 1'b0);
      en_b = 1'b0;
   endtask

   task automatic t_merge;
      thr = 8'd1; en_t = 1'b1; en_s = 1'b1; en_b = 1'b1;
      tick(1'b1, 1'b1, 1'b1); chk("R9 coincident sources pulse", got, 1'b1);
      tick(1'b0, 1'b0, 1'b0); chk("R9 coincident sources single pulse", got, 1'b0);
      en_s = 1'b0; en_b = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_modulus();
      t_zero();
      t_chan_reload();
      t_thr_write();
      t_enable();
      t_side();
      t_merge();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule